// File: doc/BRIEF.md
# External Bus Request Arbiter

This block lets an on-chip DMA engine borrow the external bus from a host processor on a bus that is also shared with peer masters. When the DMA engine raises its need for the bus, the block drives an active-low request towards the host, then watches two inputs on every rising clock edge: the host's active-low grant and a shared active-low busy line that any peer master pulls low while it owns the bus.

The bus is taken only when grant is low and busy is high in the same sample. Once owned, the block pulls its own busy output low so peers stay off, raises a bus-enable output for its address and control drivers, and gives the DMA engine a one-cycle go pulse. Loss of grant during ownership does not cut the transfer short; the DMA engine ends ownership with a done strobe, and request, busy and bus-enable are all released on the next cycle. Grant and busy arrive from outside the clock domain, so each passes through a configurable number of sampling flops before the control logic sees it.

Top module: `bus_req_arbiter`

## Requirements
- R1: During and right after reset, req_n_o and busy_n_o are 1, bus_en_o is 0 and grant_ack_o is 0.
- R2: With the block idle, dma_req_i sampled 1 on a rising edge makes req_n_o 0 from that edge on.
- R3: The block takes the bus only on an edge where its sampled grant is 0 and its sampled busy is 1; grant low with busy low, or busy high with grant high, never yields ownership.
- R4: Each of grant_n_i and busy_n_i passes through SYNC_STAGES flops; with both conditions held, ownership appears SYNC_STAGES+1 edges after the first edge that sees the last of them.
- R5: While owning, busy_n_o is 0, bus_en_o is 1 and req_n_o is 0; bus_en_o is never 1 outside ownership.
- R6: grant_ack_o is 1 for exactly the first cycle of each ownership and 0 at all other times.
- R7: While owning, grant_n_i going back to 1 or busy_n_i changing has no effect; ownership persists until dma_done_i.
- R8: dma_done_i sampled 1 while owning makes req_n_o 1, busy_n_o 1 and bus_en_o 0 from the next cycle on.
- R9: dma_req_i sampled 0 while requesting (not yet owning) withdraws the request (req_n_o 1) from that edge on, even if the grant condition is met on the same edge.
- R10: dma_done_i has no effect when the block is not owning the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_req_i | input | 1 | DMA engine needs the bus (level) |
| dma_done_i | input | 1 | DMA engine has finished its transfer (strobe) |
| grant_n_i | input | 1 | Host bus grant, active low |
| busy_n_i | input | 1 | Shared bus busy line as seen from peers, active low |
| req_n_o | output | 1 | Bus request to host, active low |
| busy_n_o | output | 1 | Own drive onto the shared busy line, active low |
| bus_en_o | output | 1 | Enables this block's address and control drivers |
| grant_ack_o | output | 1 | One-cycle pulse: DMA engine may start its cycle |

## Verification
The bench builds the block with its default of two sampling stages, which makes the input latency visible: ownership must be absent two edges after grant and busy become favourable and present on the third. That depth also separates a grant that vanishes during ownership from one that vanishes while still travelling through the sampling flops. Blocking by a busy peer, a withdrawn request racing a late grant and stray done strobes are each driven in their own scenario.

// File: rtl/bra_pkg.sv
// Package: shared state encoding for the external bus request arbiter.
// Assumes nothing beyond being compiled before the modules that import it.
package bra_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // no interest in the bus
        ST_REQ  = 2'd1,  // request driven, waiting for grant with bus free
        ST_OWN  = 2'd2   // bus owned, transfer in progress
    } bra_state_e;

endpackage

// File: rtl/bra_sync.sv
// bra_sync: delays a vector of asynchronous inputs through STAGES flops.
// With STAGES = 0 the inputs pass straight through. Assumes each bit is
// independent (no multi-bit coherence is required by the consumer).
module bra_sync #(
    parameter int          STAGES    = 2,
    parameter int          WIDTH     = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            // Purpose: no sampling delay requested.
            assign q_o = d_i;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];

            // Purpose: shift the inputs one stage per clock, reset to idle level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
                end else begin
                    stage_q[0] <= d_i;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end

            assign q_o = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/bra_fsm.sv
// bra_fsm: request / own / release sequencer for the external bus.
// Assumes grant and busy are already sampled into the clock domain.
// Abort (request dropped) takes priority over acquisition in ST_REQ.
module bra_fsm
    import bra_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dma_req_i,
    input  logic dma_done_i,
    input  logic grant_s_n_i,
    input  logic busy_s_n_i,
    output logic req_n_o,
    output logic busy_n_o,
    output logic bus_en_o,
    output logic grant_ack_o
);

    bra_state_e state_q, state_d;
    logic       ack_q;
    logic       bus_free;

    assign bus_free = !grant_s_n_i && busy_s_n_i;

    // Purpose: next-state decision from the current state and qualified inputs.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (dma_req_i) state_d = ST_REQ;
            ST_REQ: begin
                if (!dma_req_i)    state_d = ST_IDLE;
                else if (bus_free) state_d = ST_OWN;
            end
            ST_OWN:  if (dma_done_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register and the one-cycle grant acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_q   <= (state_q == ST_REQ) && (state_d == ST_OWN);
        end
    end

    assign req_n_o     = (state_q == ST_IDLE);
    assign busy_n_o    = (state_q != ST_OWN);
    assign bus_en_o    = (state_q == ST_OWN);
    assign grant_ack_o = ack_q;

    logic owning;
    assign owning = (state_q == ST_OWN);

    p_take_needs_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(owning) |-> $past(!grant_s_n_i && busy_s_n_i));

    p_hold_until_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (owning && !dma_done_i) |=> owning);

    p_abort_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ && !dma_req_i) |=> (state_q == ST_IDLE));

    p_done_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !dma_req_i && dma_done_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/bus_req_arbiter.sv
// bus_req_arbiter: lets a DMA engine obtain an external bus granted by a host
// and shared with peer masters. Grant and busy are sampled through SYNC_STAGES
// flops; the bus is taken only with grant low and busy high in one sample.
// Assumes dma_done_i is only meaningful while bus_en_o is high.
module bus_req_arbiter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_req_i,
    input  logic dma_done_i,
    input  logic grant_n_i,
    input  logic busy_n_i,
    output logic req_n_o,
    output logic busy_n_o,
    output logic bus_en_o,
    output logic grant_ack_o
);

    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] raw_in, sampled;

    assign raw_in = {grant_n_i, busy_n_i};

    bra_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (SYNC_W),
        .RST_VAL({SYNC_W{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_in),
        .q_o  (sampled)
    );

    bra_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_req_i  (dma_req_i),
        .dma_done_i (dma_done_i),
        .grant_s_n_i(sampled[1]),
        .busy_s_n_i (sampled[0]),
        .req_n_o    (req_n_o),
        .busy_n_o   (busy_n_o),
        .bus_en_o   (bus_en_o),
        .grant_ack_o(grant_ack_o)
    );

    p_req_follows_dma_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_n_o && dma_req_i) |=> !req_n_o);

    p_own_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en_o |-> (!busy_n_o && !req_n_o));

    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_ack_o |=> !grant_ack_o);

    p_ack_with_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_ack_o |-> bus_en_o);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en_o && dma_done_i) |=> (req_n_o && busy_n_o && !bus_en_o));

endmodule

// File: tb/bus_req_arbiter_tb.sv
module bus_req_arbiter_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_req = 1'b0, dma_done = 1'b0, grant_n = 1'b1, busy_n = 1'b1;
    logic req_n, busy_n_out, bus_en, ack;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk; // 125 MHz

    bus_req_arbiter #(.SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .dma_req_i(dma_req), .dma_done_i(dma_done),
        .grant_n_i(grant_n), .busy_n_i(busy_n), .req_n_o(req_n),
        .busy_n_o(busy_n_out), .bus_en_o(bus_en), .grant_ack_o(ack)
    );

    // outputs packed as {req_n, busy_n, bus_en, ack}
    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {req_n, busy_n_out, bus_en, ack};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {req_n,busy_n,bus_en,ack} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    localparam logic [3:0] IDLE_O = 4'b1100;
    localparam logic [3:0] REQ_O  = 4'b0100;
    localparam logic [3:0] OWN_O  = 4'b0010;
    localparam logic [3:0] ACK_O  = 4'b0011;

    task automatic t_reset();
        rst_n = 1'b0; dma_req = 1'b1; grant_n = 1'b0;
        step(3);
        check("R1 in reset", IDLE_O);
        dma_req = 1'b0; grant_n = 1'b1;
        rst_n = 1'b1;
        step(1);
        check("R1 after reset", IDLE_O);
    endtask

    task automatic t_basic();
        dma_req = 1'b1;
        step(1);
        check("R2 request asserted", REQ_O);
        grant_n = 1'b0;
        step(2);
        check("R4 not yet owning after 2 edges", REQ_O);
        step(1);
        check("R6 ack on first own cycle", ACK_O);
        step(1);
        check("R5 owning, ack gone", OWN_O);
        grant_n = 1'b1; busy_n = 1'b0;
        step(5);
        check("R7 grant loss ignored", OWN_O);
        busy_n = 1'b1;
        dma_done = 1'b1;
        step(1);
        dma_done = 1'b0; dma_req = 1'b0;
        check("R8 released next cycle", IDLE_O);
        step(3);
        check("R8 stays idle", IDLE_O);
    endtask

    task automatic t_busy_block();
        dma_req = 1'b1; busy_n = 1'b0;
        step(1);
        grant_n = 1'b0;
        step(6);
        check("R3 busy peer blocks", REQ_O);
        busy_n = 1'b1;
        step(2);
        check("R4 busy release latency", REQ_O);
        step(1);
        check("R3 taken once free", ACK_O);
        grant_n = 1'b1;
        dma_done = 1'b1;
        step(1);
        dma_done = 1'b0; dma_req = 1'b0;
        check("R8 release", IDLE_O);
        step(3);
    endtask

    task automatic t_no_grant();
        dma_req = 1'b1;
        step(8);
        check("R3 no grant no ownership", REQ_O);
        dma_req = 1'b0;
        step(1);
        check("R9 withdraw", IDLE_O);
    endtask

    task automatic t_abort_race();
        dma_req = 1'b1;
        step(1);
        grant_n = 1'b0;
        step(2);
        // grant reaches the FSM on the next edge; drop the request there
        dma_req = 1'b0;
        step(1);
        check("R9 abort beats grant", IDLE_O);
        step(3);
        check("R9 no ownership with grant low, no request", IDLE_O);
        grant_n = 1'b1;
        step(3);
    endtask

    task automatic t_done_idle();
        dma_done = 1'b1;
        step(3);
        check("R10 done in idle", IDLE_O);
        dma_done = 1'b0;
        dma_req = 1'b1;
        step(1);
        dma_done = 1'b1;
        step(2);
        check("R10 done while requesting", REQ_O);
        dma_done = 1'b0;
        grant_n = 1'b0;
        step(3);
        check("R6 second ownership ack", ACK_O);
        dma_done = 1'b1;
        step(1);
        dma_done = 1'b0; dma_req = 1'b0; grant_n = 1'b1;
        check("R8 second release", IDLE_O);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_busy_block();
        t_no_grant();
        t_abort_race();
        t_done_idle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule